// File: doc/BRIEF.md
# SONET Frame Alignment and Frame-Loss Monitor

This block sits behind an external serial-to-parallel converter running at the STS-12 byte rate. Each clock it takes one byte that has no known relation to the true byte boundaries. It searches for the transition from the last A1 framing byte to the A2 framing bytes at every one of the eight possible bit offsets. Once a candidate has been confirmed, it fixes the bit offset and delivers aligned bytes, each with its position in the 9720-byte frame and a marker on the first A1 byte.

While aligned, the block checks the complete block of A1 and A2 bytes once per frame at the committed offset. It keeps three alarm flags: out-of-frame, loss-of-frame and loss-of-signal. Each flag enters and leaves its state only after a set number of consecutive events. A loss-of-signal indication from outside the block is merged into the loss-of-signal output.

Top module: `sonet_frame_align`

## Requirements
- R1: Directly after reset, oof is 1, lof is 0, frame_start is 0, and los is 0 while los_ext is 0.
- R2: While out of frame, the block hunts for the 24-bit word F6h,28h,28h (bytes taken most significant bit first) at any of the eight bit offsets of the raw byte stream. oof clears only after OOF_CLR matches at the same offset, each exactly FRAME_LEN bytes after the previous one. The bit offset and the frame position are taken over only at that moment.
- R3: While in frame, data_out carries the bytes at the committed offset. frame_start is high with byte_pos 0 on the first A1 byte, and byte_pos then counts up by one per byte through FRAME_LEN-1 and wraps to 0.
- R4: While in frame, a frame passes its check when the bytes at positions 0 to AB_BYTES-1 are all F6h and the bytes at positions AB_BYTES to 2*AB_BYTES-1 are all 28h. oof is set after OOF_SET consecutive failed checks and stays clear after fewer.
- R5: lof is set after LOF_SET consecutive frame boundaries (byte_pos wrapping) with oof high, and not after fewer.
- R6: Once set, lof clears after LOF_CLR consecutive frame boundaries with oof low, and not after fewer.
- R7: The internal loss-of-signal condition is set once raw_byte has been 00h for LOS_ZERO consecutive bytes.
- R8: The internal loss-of-signal condition clears only when two correct framing checks occur exactly one frame apart with no zero-run threshold reached between them.
- R9: The los output is the OR of the internal condition and los_ext.
- R10: frame_start stays low while the block is out of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_byte | input | 8 | Unaligned byte from the serial-to-parallel converter |
| los_ext | input | 1 | Loss-of-signal indication from outside the block |
| data_out | output | 8 | Byte at the committed bit offset |
| frame_start | output | 1 | High on the first A1 byte of each frame while in frame |
| byte_pos | output | $clog2(FRAME_LEN) | Position of data_out within the frame |
| oof | output | 1 | Out-of-frame flag |
| lof | output | 1 | Loss-of-frame flag |
| los | output | 1 | Loss-of-signal flag |

## Verification
The bench builds the block with a 60-byte frame, three A1 and three A2 bytes, a zero-run threshold of 10 bytes, OOF_SET 4, OOF_CLR 2, LOF_SET 3 and LOF_CLR 2. At these values every hysteresis boundary, both the count just short of the limit and the limit itself, falls within a few frames. Relocking after a change of bit offset, and a complete loss-of-signal episode with its recovery, fit in a few thousand byte clocks. The framing byte values, the search word and the bit order are the same as at the default values, so the offset search and the framing checks are exercised exactly as they would be at full size.

// File: rtl/sonet_frame_align.sv
module sonet_frame_align #(
  parameter int FRAME_LEN = 9720,
  parameter int AB_BYTES  = 12,
  parameter int LOS_ZERO  = 1555,
  parameter int OOF_SET   = 4,
  parameter int OOF_CLR   = 2,
  parameter int LOF_SET   = 24,
  parameter int LOF_CLR   = 8,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    raw_byte,
  input  logic          los_ext,
  output logic [7:0]    data_out,
  output logic          frame_start,
  output logic [PW-1:0] byte_pos,
  output logic          oof,
  output logic          lof,
  output logic          los
);
  localparam int ZW = $clog2(LOS_ZERO + 1);
  localparam int OW = $clog2(((OOF_SET > OOF_CLR) ? OOF_SET : OOF_CLR) + 1);
  localparam int LW = $clog2(((LOF_SET > LOF_CLR) ? LOF_SET : LOF_CLR) + 1);
  localparam logic [7:0]    A1B    = 8'hF6;
  localparam logic [7:0]    A2B    = 8'h28;
  localparam logic [23:0]   PAT    = {A1B, A2B, A2B};
  localparam logic [PW-1:0] P_LAST = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] P_A2   = PW'(AB_BYTES);
  localparam logic [PW-1:0] P_END  = PW'(2 * AB_BYTES);
  localparam logic [PW-1:0] P_CHK  = PW'(2 * AB_BYTES - 1);
  localparam logic [PW-1:0] P_HIT  = PW'(AB_BYTES + 1);
  localparam logic [PW-1:0] P_NEXT = PW'(AB_BYTES + 2);
  localparam logic [ZW-1:0] Z_LAST = ZW'(LOS_ZERO - 1);
  localparam logic [ZW-1:0] Z_MAX  = ZW'(LOS_ZERO);
  localparam logic [OW-1:0] E_LAST = OW'(OOF_SET - 1);
  localparam logic [OW-1:0] H_LAST = OW'(OOF_CLR - 1);
  localparam logic [LW-1:0] L_SET  = LW'(LOF_SET - 1);
  localparam logic [LW-1:0] L_CLR  = LW'(LOF_CLR - 1);

  logic [30:0]   win;
  logic [7:0]    hit;
  logic [2:0]    hit_off, off, cand;
  logic          cand_v, acc_bad, chk_en, last_good, los_int;
  logic [PW-1:0] pos, htmr, pos_nx;
  logic [OW-1:0] ecnt, hcnt;
  logic [ZW-1:0] zcnt;
  logic [LW-1:0] lcnt;

  for (genvar k = 0; k < 8; k++) begin : g_cmp
    assign hit[k] = (win[k +: 24] == PAT);
  end

  always_comb begin
    hit_off = 3'd0;
    for (int k = 7; k >= 0; k--)
      if (hit[k]) hit_off = 3'(k);
  end

  wire [7:0] cur_byte   = win[off +: 8];
  wire       tick       = (pos == P_LAST);
  assign     pos_nx     = tick ? '0 : pos + 1'b1;
  wire [7:0] exp_byte   = (pos < P_A2) ? A1B : A2B;
  wire       mism       = (pos < P_END) && (cur_byte != exp_byte);
  wire       bad_nx     = ((pos == '0) ? 1'b0 : acc_bad) | mism;
  wire       at_chk     = !oof && chk_en && (pos == P_CHK);
  wire       sync_good  = at_chk && !bad_nx;
  wire       sync_bad   = at_chk && bad_nx;
  wire       hunt_first = oof && !cand_v && (|hit);
  wire       at_conf    = oof && cand_v && (htmr == P_HIT);
  wire       conf_ok    = at_conf && (win[cand +: 24] == PAT);
  wire       conf_bad   = at_conf && !conf_ok;
  wire       commit     = (conf_ok && hcnt == H_LAST) || (hunt_first && OOF_CLR <= 1);
  wire       zero_now   = (raw_byte == 8'h00);
  wire       los_set    = zero_now && (zcnt >= Z_LAST);

  assign los = los_int | los_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0; off <= '0; cand <= '0; cand_v <= 1'b0;
      pos <= '0; htmr <= '0; ecnt <= '0; hcnt <= '0;
      acc_bad <= 1'b0; chk_en <= 1'b0; last_good <= 1'b0;
      zcnt <= '0; los_int <= 1'b0; lcnt <= '0;
      oof <= 1'b1; lof <= 1'b0;
      data_out <= '0; frame_start <= 1'b0; byte_pos <= '0;
    end else begin
      win      <= {win[22:0], raw_byte};
      pos      <= commit ? P_NEXT : pos_nx;
      acc_bad  <= bad_nx;
      chk_en   <= commit ? 1'b0 : (chk_en | (pos == '0));
      data_out <= cur_byte;
      byte_pos <= pos;
      frame_start <= (pos == '0) && !oof;
      htmr     <= hunt_first ? P_NEXT : ((htmr == P_LAST) ? '0 : htmr + 1'b1);
      if (commit) off <= hunt_first ? hit_off : cand;

      if (sync_bad) begin
        if (ecnt == E_LAST) begin oof <= 1'b1; ecnt <= '0; end
        else ecnt <= ecnt + 1'b1;
      end else if (sync_good) ecnt <= '0;

      if (commit) begin
        oof <= 1'b0; cand_v <= 1'b0;
      end else if (hunt_first) begin
        cand <= hit_off; cand_v <= 1'b1; hcnt <= OW'(1);
      end else if (conf_ok) hcnt <= hcnt + 1'b1;
      else if (conf_bad) cand_v <= 1'b0;

      zcnt <= zero_now ? ((zcnt == Z_MAX) ? zcnt : zcnt + 1'b1) : '0;
      if (los_set || sync_bad || conf_bad || commit) last_good <= 1'b0;
      else if (hunt_first || conf_ok || sync_good) last_good <= 1'b1;
      if (los_set) los_int <= 1'b1;
      else if ((conf_ok || sync_good) && last_good) los_int <= 1'b0;

      if (tick) begin
        if (lof == oof) lcnt <= '0;
        else if (!lof && lcnt == L_SET) begin lof <= 1'b1; lcnt <= '0; end
        else if (lof && lcnt == L_CLR) begin lof <= 1'b0; lcnt <= '0; end
        else lcnt <= lcnt + 1'b1;
      end
    end
  end

  p_oof_after_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> $past(sync_bad));
  p_lock_on_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> $past(conf_ok || hunt_first));
  p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (byte_pos == PW'(1)));
  p_lof_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(oof));
  p_lof_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> !$past(oof));
  p_los_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    los_set |=> los);
endmodule

// File: tb/test_sonet_frame_align.sv
`timescale 1ns/1ps
module test_sonet_frame_align;
  localparam int FL = 60;
  localparam int N  = 3;
  localparam int PW = $clog2(FL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic los_ext = 1'b0;
  logic [7:0] data_out;
  logic frame_start, oof, lof, los;
  logic [PW-1:0] byte_pos;

  int checks = 0, failures = 0, fs_seen = 0, sb_left = 0;
  bit done = 1'b0;
  bit bitq[$];
  logic [15:0] scbq[$];

  always #10 clk = ~clk;

  sonet_frame_align #(.FRAME_LEN(FL), .AB_BYTES(N), .LOS_ZERO(10), .OOF_SET(4),
    .OOF_CLR(2), .LOF_SET(3), .LOF_CLR(2)) i_sonet_frame_align (
    .clk(clk), .rst_n(rst_n), .raw_byte(din), .los_ext(los_ext),
    .data_out(data_out), .frame_start(frame_start), .byte_pos(byte_pos),
    .oof(oof), .lof(lof), .los(los));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int p, input int kind);
    if (kind == 2) return {4'h5, p[3:0]};
    if (kind == 1 && p == N) return 8'h00;
    if (p < N) return 8'hF6;
    if (p < 2 * N) return 8'h28;
    return {4'h5, p[3:0]};
  endfunction

  task automatic drive_byte(input logic [7:0] b);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) bitq.push_back(b[i]);
    for (int i = 7; i >= 0; i--) v[i] = bitq.pop_front();
    @(negedge clk);
    din = v;
  endtask

  task automatic send_frame(input int kind, input bit scb);
    if (scb)
      for (int p = 0; p < 2 * N + 4; p++) scbq.push_back({8'(p), fbyte(p, kind)});
    for (int p = 0; p < FL; p++) drive_byte(fbyte(p, kind));
  endtask

  always @(negedge clk) begin
    logic [15:0] item;
    if (frame_start) fs_seen++;
    if (sb_left == 0 && frame_start && scbq.size() > 0) sb_left = 2 * N + 4;
    if (sb_left > 0) begin
      item = scbq.pop_front();
      chk(data_out == item[7:0], "R3 aligned byte", int'(data_out), int'(item[7:0]));
      chk(int'(byte_pos) == int'(item[15:8]), "R3 byte position", int'(byte_pos), int'(item[15:8]));
      sb_left--;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int fs0;
    repeat (4) @(negedge clk);
    chk(oof == 1'b1, "R1 oof at reset", oof, 1);
    chk(lof == 1'b0, "R1 lof at reset", lof, 0);
    chk(los == 1'b0, "R1 los at reset", los, 0);
    chk(frame_start == 1'b0, "R1 frame_start at reset", frame_start, 0);
    rst_n = 1'b1;
    bitq.push_back(1'b1); bitq.push_back(1'b0); bitq.push_back(1'b1);

    send_frame(0, 1'b0);
    chk(oof == 1'b1, "R2 one match does not lock", oof, 1);
    send_frame(0, 1'b0);
    chk(oof == 1'b0, "R2 lock after two matches", oof, 0);
    send_frame(0, 1'b1);
    send_frame(0, 1'b1);
    send_frame(0, 1'b0);

    for (int f = 0; f < 3; f++) send_frame(1, 1'b0);
    chk(oof == 1'b0, "R4 three bad frames keep frame", oof, 0);
    send_frame(1, 1'b0);
    chk(oof == 1'b1, "R4 fourth bad frame sets oof", oof, 1);

    fs0 = fs_seen;
    send_frame(2, 1'b0);
    chk(lof == 1'b0, "R5 lof not yet set", lof, 0);
    for (int f = 0; f < 4; f++) send_frame(2, 1'b0);
    chk(lof == 1'b1, "R5 lof set after frames in oof", lof, 1);
    chk(fs_seen == fs0, "R10 no frame_start while oof", fs_seen - fs0, 0);

    send_frame(0, 1'b0);
    chk(oof == 1'b1, "R2 relock needs second match", oof, 1);
    send_frame(0, 1'b0);
    chk(oof == 1'b0, "R2 relock", oof, 0);
    chk(lof == 1'b1, "R6 lof held right after relock", lof, 1);
    for (int f = 0; f < 4; f++) send_frame(0, 1'b0);
    chk(lof == 1'b0, "R6 lof cleared", lof, 0);

    for (int i = 0; i < 6; i++) bitq.push_back(1'b1);
    for (int i = 0; i < 8; i++) drive_byte(8'h00);
    chk(los == 1'b0, "R7 short zero run", los, 0);
    for (int i = 0; i < 6; i++) drive_byte(8'h00);
    chk(los == 1'b1, "R7 long zero run sets los", los, 1);
    for (int f = 0; f < 3; f++) send_frame(0, 1'b0);
    chk(los == 1'b1, "R8 los held without two spaced checks", los, 1);
    for (int f = 0; f < 5; f++) send_frame(0, 1'b0);
    chk(los == 1'b0, "R8 los cleared", los, 0);
    chk(oof == 1'b0, "R2 lock at new bit offset", oof, 0);
    send_frame(0, 1'b1);
    send_frame(0, 1'b1);
    send_frame(0, 1'b0);
    chk(scbq.size() == 0, "R3 all expected bytes seen", scbq.size(), 0);

    los_ext = 1'b1;
    #1;
    chk(los == 1'b1, "R9 external los", los, 1);
    los_ext = 1'b0;
    #1;
    chk(los == 1'b0, "R9 external los released", los, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule